// File: doc/BRIEF.md
# Acquisition Interrupt Controller

This block collects event signals from a data-acquisition board: the analog-input sequencer, the analog-output waveform engine, fill counts from the ADC and DAC FIFOs, and one external interrupt pin. It keeps one status bit per source. Software enables each source on its own. The enabled pending sources together drive a single active-low interrupt line to the host.

Sources that report a single event are sticky. Each sets its status bit and holds it until software writes a 1 to that bit. Sources that report a condition (sequencer active, waveform engine active, FIFO quarter thresholds) follow that condition one clock later and ignore clear writes. The external pin passes through a synchronizer. It is edge sensitive, and a control bit picks rising or falling edges.

The register port has no wait states. A write takes effect at the clock edge on which it is presented. Reads are combinational on the read address.

Top module: `acq_irq_ctrl`

## Requirements
- R1: After reset the status, enable and control registers read 0, and irq_no is high. A control value of 0 means rising-edge external triggering.
- R2: A high pulse on ai_pulse_i[k] sets status bit k at the next clock edge, and the bit stays set until it is cleared. The bit order is k=0 stop trigger, 1 sequence done, 2 single conversion, 3 end of scan, 4 interval elapsed.
- R3: A high pulse on ao_pulse_i[k] sets status bit 5+k at the next edge, and the bit stays set until it is cleared. The bit order is k=0 output sequence done, 1 high channel updated, 2 retransmit wrap.
- R4: Status bit 9 follows ai_active_i and status bit 11 follows ao_active_i, each one clock later. A clear write to either bit has no effect.
- R5: Status bit 10 is set one clock after adc_fill_i >= ADC_DEPTH/4, and it is clear otherwise.
- R6: Status bit 12 is set one clock after dac_fill_i <= DAC_DEPTH/4, and it is clear otherwise.
- R7: ext_irq_i is synchronized by two flops. A qualifying edge sets status bit 8 on the third clock edge after the pin changes, and it sets the bit only once per edge. Control bit 0 at address 2 selects the edge: 0 is rising, 1 is falling.
- R8: A write to address 0 clears each event status bit (bits 0 to 8) where the written data is 1. All other bits are left unchanged.
- R9: If an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R10: The enable register at address 1 holds bits 12:0 and reads back what was written. irq_no is low exactly when status AND enable is non-zero. It goes high in the cycle after the write that clears the last enabled pending bit.
- R11: rd_data_o returns status at address 0, enable at address 1, control at address 2 and zero at address 3. Unused upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ai_pulse_i | input | 5 | Analog-input event pulses |
| ai_active_i | input | 1 | Analog-input sequence running |
| adc_fill_i | input | ADC_CNT_W | ADC FIFO fill count |
| ao_pulse_i | input | 3 | Analog-output event pulses |
| ao_active_i | input | 1 | Waveform engine running |
| dac_fill_i | input | DAC_CNT_W | DAC FIFO fill count |
| ext_irq_i | input | 1 | External interrupt pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Register read data |
| irq_no | output | 1 | Host interrupt, active low |

## Verification
A status bit that is wrong internally shows up at rd_data_o on the very next read. On an enabled source it also shows up on irq_no in the same cycle, because the line is combinational on the status and enable flops. A sticky bit that drops by itself, or a level bit that latches, shows up one clock after the input moves. An error in the edge path shows up as a missing status bit, or a repeated one, three edges after the pin changes, and the bench checks both sides of that window.

// File: rtl/acq_irq_pkg.sv
package acq_irq_pkg;
  localparam int NUM_SRC    = 13;
  localparam int AI_PULSE_N = 5;
  localparam int AO_PULSE_N = 3;
  localparam int BIT_EXT    = AI_PULSE_N + AO_PULSE_N;
  localparam int BIT_AI_ACT = BIT_EXT + 1;
  localparam int BIT_ADC_QF = BIT_EXT + 2;
  localparam int BIT_AO_ACT = BIT_EXT + 3;
  localparam int BIT_DAC_QE = BIT_EXT + 4;
  localparam logic [NUM_SRC-1:0] LEVEL_MASK = 13'h1E00;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_ENABLE = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/acq_irq_level_mon.sv
module acq_irq_level_mon #(
  parameter int DEPTH       = 64,
  parameter int CNT_W       = $clog2(DEPTH) + 1,
  parameter bit AT_OR_ABOVE = 1'b1
) (
  input  logic [CNT_W-1:0] fill_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] QUARTER = CNT_W'(DEPTH / 4);

  generate
    if (AT_OR_ABOVE) begin : g_ge
      assign hit_o = (fill_i >= QUARTER);
    end else begin : g_le
      assign hit_o = (fill_i <= QUARTER);
    end
  endgenerate
endmodule

// File: rtl/acq_irq_ext_edge.sv
module acq_irq_ext_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], pin_i};
  end

  // sh_q[SYNC_N-1] is synchronized level, sh_q[SYNC_N] its previous value
  assign edge_o = fall_sel_i ? (~sh_q[SYNC_N-1] &  sh_q[SYNC_N])
                             : ( sh_q[SYNC_N-1] & ~sh_q[SYNC_N]);

  // R7
  single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && $stable(fall_sel_i) |=> !edge_o || $changed(fall_sel_i));
endmodule

// File: rtl/acq_irq_status.sv
module acq_irq_status
  import acq_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  localparam logic [NUM_SRC-1:0] EVT_MASK = ~LEVEL_MASK;
  logic [NUM_SRC-1:0] status_q;

  // set has priority over clear; level bits are not sticky
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else status_q <= ((((status_q & ~clr_i) | set_i) & EVT_MASK) |
                      (level_i & LEVEL_MASK));
  end

  assign status_o = status_q;

  // R9
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & EVT_MASK) != '0) |=>
      ((status_q & $past(set_i & EVT_MASK)) == $past(set_i & EVT_MASK)));

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(status_q) & ~$past(clr_i) & EVT_MASK) & ~status_q) == '0));

  // R4
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((status_q & LEVEL_MASK) == $past(level_i & LEVEL_MASK)));
endmodule

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl
  import acq_irq_pkg::*;
#(
  parameter int ADC_DEPTH = 64,
  parameter int DAC_DEPTH = 64,
  parameter int ADC_CNT_W = $clog2(ADC_DEPTH) + 1,
  parameter int DAC_CNT_W = $clog2(DAC_DEPTH) + 1,
  parameter int DATA_W    = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AI_PULSE_N-1:0] ai_pulse_i,
  input  logic                  ai_active_i,
  input  logic [ADC_CNT_W-1:0]  adc_fill_i,
  input  logic [AO_PULSE_N-1:0] ao_pulse_i,
  input  logic                  ao_active_i,
  input  logic [DAC_CNT_W-1:0]  dac_fill_i,
  input  logic                  ext_irq_i,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [1:0]            rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  irq_no
);
  logic               adc_qf, dac_qe, ext_edge, fall_sel_q;
  logic [NUM_SRC-1:0] en_q, status, set_vec, lvl_vec, clr_vec;

  acq_irq_level_mon #(.DEPTH(ADC_DEPTH), .CNT_W(ADC_CNT_W), .AT_OR_ABOVE(1'b1))
    u_adc_mon (.fill_i(adc_fill_i), .hit_o(adc_qf));

  acq_irq_level_mon #(.DEPTH(DAC_DEPTH), .CNT_W(DAC_CNT_W), .AT_OR_ABOVE(1'b0))
    u_dac_mon (.fill_i(dac_fill_i), .hit_o(dac_qe));

  acq_irq_ext_edge #(.SYNC_N(2)) u_ext (
    .clk_i, .rst_ni, .pin_i(ext_irq_i), .fall_sel_i(fall_sel_q), .edge_o(ext_edge)
  );

  assign set_vec = {{(NUM_SRC-BIT_EXT-1){1'b0}}, ext_edge, ao_pulse_i, ai_pulse_i};
  assign lvl_vec = {dac_qe, ao_active_i, adc_qf, ai_active_i, {BIT_EXT+1{1'b0}}};
  assign clr_vec = (wr_en_i && wr_addr_i == REG_STATUS) ? wr_data_i[NUM_SRC-1:0] : '0;

  acq_irq_status u_status (
    .clk_i, .rst_ni, .set_i(set_vec), .level_i(lvl_vec), .clr_i(clr_vec),
    .status_o(status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= '0;
      fall_sel_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_ENABLE) en_q       <= wr_data_i[NUM_SRC-1:0];
      if (wr_addr_i == REG_CTRL)   fall_sel_q <= wr_data_i[0];
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      REG_STATUS: rd_data_o = {{(DATA_W-NUM_SRC){1'b0}}, status};
      REG_ENABLE: rd_data_o = {{(DATA_W-NUM_SRC){1'b0}}, en_q};
      REG_CTRL:   rd_data_o = {{(DATA_W-1){1'b0}}, fall_sel_q};
      default:    rd_data_o = '0;
    endcase
  end

  assign irq_no = ~|(status & en_q);

  // R10
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (en_q != '0) && (status != '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> irq_no);
endmodule

// File: tb/acq_irq_ctrl_tb.sv
module acq_irq_ctrl_tb;
  localparam int ADC_CNT_W = 7;
  localparam int DAC_CNT_W = 7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  ai_pulse = '0;
  logic        ai_active = 1'b0;
  logic [ADC_CNT_W-1:0] adc_fill = '0;
  logic [2:0]  ao_pulse = '0;
  logic        ao_active = 1'b0;
  logic [DAC_CNT_W-1:0] dac_fill = 7'd40;
  logic        ext_irq = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acq_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ai_pulse_i(ai_pulse), .ai_active_i(ai_active),
    .adc_fill_i(adc_fill), .ao_pulse_i(ao_pulse), .ao_active_i(ao_active),
    .dac_fill_i(dac_fill), .ext_irq_i(ext_irq), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_no(irq_no)
  );

  // {ai_pulse, ao_pulse, expected status}
  localparam logic [20:0] VEC [6] = '{
    {5'b00001, 3'b000, 13'h0001},
    {5'b00010, 3'b000, 13'h0002},
    {5'b10100, 3'b000, 13'h0014},
    {5'b00000, 3'b001, 13'h0020},
    {5'b00000, 3'b110, 13'h00C0},
    {5'b11111, 3'b111, 13'h00FF}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [15:0] d;
    #1;
    rd(2'd0, d); chk("R1 status", d, 16'h0);
    chk("R1 irq_no", {15'b0, irq_no}, 16'h1);
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    rd(2'd0, d); chk("R1 status", d, 16'h0);
    rd(2'd1, d); chk("R1 enable", d, 16'h0);
    rd(2'd2, d); chk("R1 ctrl", d, 16'h0);
    chk("R1 irq_no", {15'b0, irq_no}, 16'h1);

    // R2 R3 table
    foreach (VEC[i]) begin
      wr(2'd0, 16'h1FFF);
      ai_pulse = VEC[i][20:16]; ao_pulse = VEC[i][15:13];
      tick();
      ai_pulse = '0; ao_pulse = '0;
      rd(2'd0, d); chk("R2/R3 latch", d, {3'b0, VEC[i][12:0]});
      repeat (2) tick();
      rd(2'd0, d); chk("R2/R3 sticky", d, {3'b0, VEC[i][12:0]});
    end

    // R8 partial clear: status is 0x00FF
    wr(2'd0, 16'h0005);
    rd(2'd0, d); chk("R8 partial clear", d, 16'h00FA);
    wr(2'd0, 16'h1FFF);
    rd(2'd0, d); chk("R8 full clear", d, 16'h0000);

    // R4 level bits
    ai_active = 1'b1; tick();
    rd(2'd0, d); chk("R4 ai_active set", d, 16'h0200);
    wr(2'd0, 16'h0200);
    rd(2'd0, d); chk("R4 clear ignored", d, 16'h0200);
    ai_active = 1'b0; ao_active = 1'b1; tick();
    rd(2'd0, d); chk("R4 ao_active follow", d, 16'h0800);
    ao_active = 1'b0; tick();
    rd(2'd0, d); chk("R4 levels drop", d, 16'h0000);

    // R5 ADC quarter full, threshold 16
    adc_fill = 7'd15; tick(); rd(2'd0, d); chk("R5 below", d, 16'h0000);
    adc_fill = 7'd16; tick(); rd(2'd0, d); chk("R5 at", d, 16'h0400);
    adc_fill = 7'd64; tick(); rd(2'd0, d); chk("R5 full", d, 16'h0400);
    adc_fill = 7'd0;  tick();

    // R6 DAC quarter empty, threshold 16
    dac_fill = 7'd17; tick(); rd(2'd0, d); chk("R6 above", d, 16'h0000);
    dac_fill = 7'd16; tick(); rd(2'd0, d); chk("R6 at", d, 16'h1000);
    dac_fill = 7'd0;  tick(); rd(2'd0, d); chk("R6 empty", d, 16'h1000);
    dac_fill = 7'd40; tick();

    // R7 rising edge, latency 3
    ext_irq = 1'b1;
    repeat (2) tick(); rd(2'd0, d); chk("R7 not yet", d, 16'h0000);
    tick(); rd(2'd0, d); chk("R7 rising", d, 16'h0100);
    wr(2'd0, 16'h0100);
    repeat (5) tick(); rd(2'd0, d); chk("R7 once per edge", d, 16'h0000);
    ext_irq = 1'b0;
    repeat (5) tick(); rd(2'd0, d); chk("R7 fall ignored", d, 16'h0000);
    wr(2'd2, 16'h0001);
    rd(2'd2, d); chk("R7 ctrl readback", d, 16'h0001);
    ext_irq = 1'b1;
    repeat (5) tick(); rd(2'd0, d); chk("R7 rise ignored", d, 16'h0000);
    ext_irq = 1'b0;
    repeat (3) tick(); rd(2'd0, d); chk("R7 falling", d, 16'h0100);
    wr(2'd0, 16'h0100);

    // R9 event beats clear
    ai_pulse = 5'b00100; tick(); ai_pulse = '0;
    ai_pulse = 5'b00100; wr(2'd0, 16'h0004); ai_pulse = '0;
    rd(2'd0, d); chk("R9 event wins", d, 16'h0004);

    // R10 enable and line
    chk("R10 disabled", {15'b0, irq_no}, 16'h1);
    wr(2'd1, 16'h0004);
    rd(2'd1, d); chk("R10 enable readback", d, 16'h0004);
    chk("R10 asserted", {15'b0, irq_no}, 16'h0);
    wr(2'd1, 16'h0001);
    chk("R10 masked", {15'b0, irq_no}, 16'h1);
    wr(2'd1, 16'h0204);
    chk("R10 reasserted", {15'b0, irq_no}, 16'h0);
    wr(2'd0, 16'h0004);
    chk("R10 cleared", {15'b0, irq_no}, 16'h1);
    ai_active = 1'b1; tick();
    chk("R10 level source", {15'b0, irq_no}, 16'h0);
    ai_active = 1'b0; tick();
    chk("R10 level drop", {15'b0, irq_no}, 16'h1);

    // R11 unused address
    rd(2'd3, d); chk("R11 addr3 zero", d, 16'h0000);

    done = 1'b1;
    summary();
  end
endmodule